// File: doc/BRIEF.md
# DMA Channel Event Trigger Controller

This block holds the event-control word of a single DMA channel and turns system events into one-cycle commands for the channel engine. It watches an interrupt request bus that carries one event per cycle: a valid flag and an 8-bit interrupt number. It compares each event against two programmable selectors. A match on the start selector makes the block issue a start command. A match on the abort selector makes it issue an abort command and latch a sticky abort-interrupt flag.

Software can also issue commands through two command bits that clear themselves. One forces a start and the other forces an abort. If pattern-abort is enabled, a pattern-match indication from the channel aborts the transfer and clears the channel enable. When a start and an abort arise in the same cycle, only the abort is issued. Every output is registered, so each output reacts on the clock edge that follows its cause.

The event bus has no back-pressure. There is no ready signal, and every valid event is taken in the cycle it is presented. The register bus is a plain select/write/read interface with combinational read data.

Top module: `dma_evt_trig`

## Requirements
- R1: After reset, every configuration field is 0, the read word is 0, and start_pulse, abort_pulse, chan_en_clr and abort_flag are all low.
- R2: A write with reg_sel high stores the fields at these bit positions: abort selector [23:16], start selector [15:8], pattern-abort enable [5], start-event enable [4], abort-event enable [3]. A read returns them at the same positions. Bits [31:24] and [2:0] always read 0, and data written there has no effect.
- R3: When the start-event enable is 1, an event with irq_valid high and irq_num equal to the start selector (0 to 255, both ends included) gives a one-cycle start_pulse on the next clock. When the enable is 0, that event gives no start_pulse.
- R4: When the abort-event enable is 1, an event whose number equals the abort selector gives a one-cycle abort_pulse on the next clock and sets abort_flag. When the enable is 0, that event changes neither output.
- R5: Writing 1 to bit [7] (force start) gives a one-cycle start_pulse on the next clock. Bit [7] always reads 0.
- R6: Writing 1 to bit [6] (abort command) gives a one-cycle abort_pulse on the next clock and leaves abort_flag unchanged. Bit [6] always reads 0.
- R7: With pattern-abort enabled, pat_match high gives abort_pulse and chan_en_clr together on the next clock. With it disabled, pat_match has no effect.
- R8: If any start cause and any abort cause occur in the same cycle, only abort_pulse is issued and start_pulse stays low.
- R9: abort_flag stays high until a cycle with flag_clr high. If a flag-setting event arrives in the same cycle as flag_clr, the flag ends up set.
- R10: Events are decoded against the configuration held before the current cycle's write. An event whose number matches no selector, or whose irq_valid is low, produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, 0 unless selected and reading |
| irq_valid | input | 1 | Event present this cycle |
| irq_num | input | 8 | Event number |
| pat_match | input | 1 | Pattern match from the channel |
| flag_clr | input | 1 | Clears abort_flag |
| start_pulse | output | 1 | One-cycle start command |
| abort_pulse | output | 1 | One-cycle abort command |
| chan_en_clr | output | 1 | One-cycle channel-enable clear |
| abort_flag | output | 1 | Sticky abort-interrupt flag |

## Verification
The decoder is driven with several kinds of event: a matching event, a number just next to a selector, a matching number with valid low, and the selector extremes 0x00 and 0xFF. Together these show an exact compare apart from a masked or off-by-one compare. Each enable is tested both on and off, which shows whether it gates its own decode or a neighbour's. Start and abort causes are combined in pairs: force with abort command, event with abort command, and pattern with event. This exposes any lost priority. Writing the selector in the same cycle as a matching event shows whether decode uses the old or the new configuration.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int DW       = 32;
  localparam int IRQ_W    = 8;
  localparam int ABRT_LSB = 16;
  localparam int STRT_LSB = ABRT_LSB - IRQ_W;
  localparam int FORCE_B  = STRT_LSB - 1;
  localparam int ACMD_B   = FORCE_B - 1;
  localparam int PATEN_B  = ACMD_B - 1;
  localparam int SEN_B    = PATEN_B - 1;
  localparam int AEN_B    = SEN_B - 1;
  localparam int NSEL     = 2;   // selector 0: start, selector 1: abort

  typedef logic [IRQ_W-1:0] irq_num_t;

  typedef struct packed {
    irq_num_t abrt_sel;
    irq_num_t strt_sel;
    logic     pat_en;
    logic     strt_en;
    logic     abrt_en;
  } evt_cfg_t;
endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
  import dma_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output evt_cfg_t      cfg,
  output logic          force_cmd,
  output logic          abrt_cmd,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.abrt_sel <= wdata[ABRT_LSB +: IRQ_W];
      cfg.strt_sel <= wdata[STRT_LSB +: IRQ_W];
      cfg.pat_en   <= wdata[PATEN_B];
      cfg.strt_en  <= wdata[SEN_B];
      cfg.abrt_en  <= wdata[AEN_B];
    end
  end

  // command bits are never stored, so they read back as zero
  assign force_cmd = wr_en & wdata[FORCE_B];
  assign abrt_cmd  = wr_en & wdata[ACMD_B];

  always_comb begin
    word = '0;
    word[ABRT_LSB +: IRQ_W] = cfg.abrt_sel;
    word[STRT_LSB +: IRQ_W] = cfg.strt_sel;
    word[PATEN_B]           = cfg.pat_en;
    word[SEN_B]             = cfg.strt_en;
    word[AEN_B]             = cfg.abrt_en;
  end
endmodule

// File: rtl/evt_irq_match.sv
module evt_irq_match #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         valid,
  input  logic [W-1:0] num,
  input  logic [W-1:0] sel,
  output logic         hit
);
  assign hit = en & valid & (num == sel);
endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic strt_evt,
  input  logic abrt_evt,
  input  logic pat_hit,
  input  logic irq_abrt_hit,
  input  logic flag_clr,
  output logic start_o,
  output logic abort_o,
  output logic en_clr_o,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_o  <= 1'b0;
      abort_o  <= 1'b0;
      en_clr_o <= 1'b0;
      flag_o   <= 1'b0;
    end else begin
      start_o  <= strt_evt & ~abrt_evt;
      abort_o  <= abrt_evt;
      en_clr_o <= pat_hit;
      if (irq_abrt_hit)  flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
    end
  end

  a_r8_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !abort_o);
  a_r7_clr_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_o |-> abort_o);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !flag_clr |=> flag_o);
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abrt_hit |=> flag_o && abort_o);
endmodule

// File: rtl/dma_evt_trig.sv
module dma_evt_trig
  import dma_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             irq_valid,
  input  logic [IRQ_W-1:0] irq_num,
  input  logic             pat_match,
  input  logic             flag_clr,
  output logic             start_pulse,
  output logic             abort_pulse,
  output logic             chan_en_clr,
  output logic             abort_flag
);
  evt_cfg_t      cfg;
  logic          force_cmd, abrt_cmd;
  logic [DW-1:0] word;
  logic [NSEL-1:0] sel_en;
  irq_num_t        sel_num [NSEL];
  logic [NSEL-1:0] sel_hit;
  logic            pat_hit;

  evt_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_sel & reg_wr), .wdata(reg_wdata),
    .cfg(cfg), .force_cmd(force_cmd), .abrt_cmd(abrt_cmd), .word(word)
  );

  assign sel_en[0]  = cfg.strt_en;
  assign sel_num[0] = cfg.strt_sel;
  assign sel_en[1]  = cfg.abrt_en;
  assign sel_num[1] = cfg.abrt_sel;

  for (genvar g = 0; g < NSEL; g++) begin : g_match
    evt_irq_match #(.W(IRQ_W)) u_m (
      .en(sel_en[g]), .valid(irq_valid), .num(irq_num),
      .sel(sel_num[g]), .hit(sel_hit[g])
    );
  end

  assign pat_hit = cfg.pat_en & pat_match;

  evt_pulse_gen u_pg (
    .clk(clk), .rst_n(rst_n),
    .strt_evt(sel_hit[0] | force_cmd),
    .abrt_evt(sel_hit[1] | abrt_cmd | pat_hit),
    .pat_hit(pat_hit), .irq_abrt_hit(sel_hit[1]), .flag_clr(flag_clr),
    .start_o(start_pulse), .abort_o(abort_pulse),
    .en_clr_o(chan_en_clr), .flag_o(abort_flag)
  );

  assign reg_rdata = (reg_sel & reg_rd) ? word : '0;

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:ABRT_LSB+IRQ_W] == '0 && reg_rdata[ACMD_B+1:ACMD_B] == 2'b00);
  a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !cfg.strt_en && !(reg_sel && reg_wr && reg_wdata[FORCE_B])
    |=> !start_pulse);
  a_r7_pattern_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.pat_en |=> !chan_en_clr);
endmodule

// File: tb/tb_dma_evt_trig.sv
`timescale 1ns/1ps
module tb_dma_evt_trig;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_valid = 0;
  logic [7:0]  irq_num = '0;
  logic        pat_match = 0, flag_clr = 0;
  logic        start_pulse, abort_pulse, chan_en_clr, abort_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_evt_trig dut (.*);

  typedef struct {
    logic [3:0]  outs;   // start, abort, en_clr, flag
    bit          ck_rd;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic cyc(input bit wr, input logic [31:0] wd, input bit rd,
                     input bit iv, input logic [7:0] num, input bit pm, input bit fc,
                     input logic [3:0] eo, input bit ck, input logic [31:0] erd,
                     input string tag);
    exp_t e;
    @(negedge clk);
    reg_sel = wr | rd; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
    irq_valid = iv; irq_num = num; pat_match = pm; flag_clr = fc;
    e.outs = eo; e.ck_rd = ck; e.rd = erd; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare after the edge that captured the stimulus
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({start_pulse, abort_pulse, chan_en_clr, abort_flag} !== e.outs ||
          (e.ck_rd && reg_rdata !== e.rd)) begin
        fails++;
        $display("FAIL %s: outs=%b rdata=%h expected outs=%b rdata=%h",
                 e.tag, {start_pulse, abort_pulse, chan_en_clr, abort_flag},
                 reg_rdata, e.outs, e.rd);
      end
    end
  end

  function automatic logic [31:0] w(input logic [7:0] a, input logic [7:0] s,
                                    input logic [7:0] lo);
    return {8'h00, a, s, lo};
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({start_pulse, abort_pulse, chan_en_clr, abort_flag, reg_rdata} !== '0) begin
      fails++;
      $display("FAIL R1: outs=%b rdata=%h expected 0", {start_pulse, abort_pulse,
               chan_en_clr, abort_flag}, reg_rdata);
    end
    rst_n = 1'b1;
    cyc(0,0,1, 0,0,0,0, 4'b0000, 1, 32'h0, "R1 reset read");
    cyc(1,w(8'h42,8'h17,8'h18),0, 0,0,0,0, 4'b0000, 0, 0, "R2 write");
    cyc(0,0,1, 0,0,0,0, 4'b0000, 1, 32'h00421718, "R2 readback");
    cyc(1,32'hFF42171F,0, 0,0,0,0, 4'b0000, 0, 0, "R2 reserved write");
    cyc(0,0,1, 0,0,0,0, 4'b0000, 1, 32'h00421718, "R2 reserved read");
    cyc(0,0,0, 1,8'h17,0,0, 4'b1000, 0, 0, "R3 start irq");
    cyc(0,0,0, 0,0,0,0, 4'b0000, 0, 0, "R3 single pulse");
    cyc(0,0,0, 1,8'h18,0,0, 4'b0000, 0, 0, "R10 near miss");
    cyc(0,0,0, 0,8'h17,0,0, 4'b0000, 0, 0, "R10 valid low");
    cyc(0,0,0, 1,8'h42,0,0, 4'b0101, 0, 0, "R4 abort irq");
    cyc(0,0,0, 0,0,0,0, 4'b0001, 0, 0, "R9 flag holds");
    cyc(0,0,0, 0,0,0,1, 4'b0000, 0, 0, "R9 flag clear");
    cyc(1,w(8'h42,8'h17,8'h98),0, 0,0,0,0, 4'b1000, 0, 0, "R5 force");
    cyc(0,0,1, 0,0,0,0, 4'b0000, 1, 32'h00421718, "R5 force reads 0");
    cyc(1,w(8'h42,8'h17,8'h58),0, 0,0,0,0, 4'b0100, 0, 0, "R6 abort cmd");
    cyc(0,0,1, 0,0,0,0, 4'b0000, 1, 32'h00421718, "R6 abort reads 0");
    cyc(1,w(8'h42,8'h17,8'hD8),0, 0,0,0,0, 4'b0100, 0, 0, "R8 force+abort");
    cyc(1,w(8'h42,8'h17,8'h58),0, 1,8'h17,0,0, 4'b0100, 0, 0, "R8 irq+abort cmd");
    cyc(0,0,0, 0,0,1,0, 4'b0000, 0, 0, "R7 pattern disabled");
    cyc(1,w(8'h42,8'h17,8'h38),0, 0,0,0,0, 4'b0000, 0, 0, "R7 enable write");
    cyc(0,0,0, 0,0,1,0, 4'b0110, 0, 0, "R7 pattern abort");
    cyc(0,0,0, 1,8'h17,1,0, 4'b0110, 0, 0, "R8 pattern+start irq");
    cyc(1,w(8'h42,8'h17,8'h28),0, 0,0,0,0, 4'b0000, 0, 0, "R3 disable write");
    cyc(0,0,0, 1,8'h17,0,0, 4'b0000, 0, 0, "R3 start disabled");
    cyc(1,w(8'h42,8'h17,8'h20),0, 0,0,0,0, 4'b0000, 0, 0, "R4 disable write");
    cyc(0,0,0, 1,8'h42,0,0, 4'b0000, 0, 0, "R4 abort disabled");
    cyc(1,w(8'h42,8'h17,8'h28),0, 0,0,0,0, 4'b0000, 0, 0, "R4 enable write");
    cyc(0,0,0, 1,8'h42,0,1, 4'b0101, 0, 0, "R9 set beats clear");
    cyc(1,w(8'h00,8'hFF,8'h18),0, 0,0,0,0, 4'b0001, 0, 0, "R3 edge write");
    cyc(0,0,0, 1,8'hFF,0,0, 4'b1001, 0, 0, "R3 selector 255");
    cyc(0,0,0, 1,8'h00,0,0, 4'b0101, 0, 0, "R4 selector 0");
    cyc(1,w(8'h00,8'h01,8'h18),0, 1,8'hFF,0,0, 4'b1001, 0, 0, "R10 old config");
    cyc(0,0,0, 1,8'hFF,0,0, 4'b0001, 0, 0, "R10 old selector gone");
    cyc(0,0,0, 1,8'h01,0,0, 4'b1001, 0, 0, "R10 new selector");
    cyc(0,0,0, 0,0,0,1, 4'b0000, 0, 0, "R9 final clear");
    cyc(0,0,0, 0,0,0,0, 4'b0000, 0, 0, "R9 idle");
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule